// File: doc/BRIEF.md
# Interrupt Sampling and Vectoring Controller

This block is the interrupt front end of a small 8-bit microcontroller core. A machine cycle lasts several clocks. At one fixed point inside every machine cycle, marked by a sample strobe, the block captures the interrupt request lines. When that machine cycle closes, the captured set moves into a poll register. The block examines the poll register during the following machine cycle and decides at its close whether to ask the core for a hardware long call.

Before arbitration the polled set is masked by a global enable and by per-source enables. A per-source priority bit places each source in the high or the low group. Each group has its own in-service flag. A call is withheld in four cases: a service routine of equal or higher level is running, the current machine cycle is not the last one of its instruction, the instruction is a return from interrupt, or the instruction writes the enable or priority setting. Requests that are turned away are not stored. The core performs the long call and the stack push from the one-clock request pulse and the vector address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The request lines are captured only in clocks where `sample_stb` is high. The call decision made at the `mcyc_stb` clock of a machine cycle uses the set captured during the previous machine cycle. Line values outside the sample strobe have no effect.
- R2: A captured request takes part in arbitration only when `glb_en` is 1 and its own `src_en` bit is 1.
- R3: An enabled request whose `src_hi` bit is 1 wins over every low request. Within one group, the lowest source index wins.
- R4: No call is issued while an interrupt of equal or higher level is in service. A high request may interrupt a low routine. A low request is blocked while `in_svc[1]` is set.
- R5: No call is issued in a machine cycle whose `last_cyc` is 0 at its `mcyc_stb` clock.
- R6: No call is issued in a machine cycle in which `reti_ins` or `ctl_write` is 1.
- R7: A request that was blocked is not remembered. If its line is low at the next sample point, no call ever follows for it.
- R8: `call_req` is high for exactly one clock. Together with it, `vec_addr` equals 3 + 8·n for the winning source n.
- R9: `in_svc[1]` (high) or `in_svc[0]` (low) is set at the same edge that raises `call_req` for that group. At the `mcyc_stb` clock of a machine cycle with `reti_ins` and `last_cyc` both 1, the highest set flag is cleared.
- R10: While `rst_n` is low, `call_req` is 0, `in_svc` is 0 and all captured requests are cleared. Reset is applied asynchronously and released on a clock.
- R11: `call_req` rises only in the clock that follows a clock in which `mcyc_stb` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_flags | input | NUM_SRC | Interrupt request lines |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | NUM_SRC | Per-source enable |
| src_hi | input | NUM_SRC | Per-source priority, 1 = high group |
| sample_stb | input | 1 | Capture point inside the machine cycle |
| mcyc_stb | input | 1 | Last clock of a machine cycle |
| last_cyc | input | 1 | Current machine cycle ends its instruction |
| reti_ins | input | 1 | Instruction is a return from interrupt |
| ctl_write | input | 1 | Instruction writes the enable or priority setting |
| call_req | output | 1 | One-clock long-call request |
| vec_addr | output | ADDR_W | Service routine address |
| in_svc | output | 2 | In-service flags, bit 1 high, bit 0 low |

## Verification
A request captured in machine cycle C1 is decided at the `mcyc_stb` clock of C2. `call_req`, `vec_addr` and `in_svc` change on that same edge. They are therefore observed on the first clock of C3, and `call_req` must be low again on the second clock of C3. The bench drives and samples on falling edges. It records the outputs at the start of every machine cycle and compares each scenario's result at exactly that point. It also checks that nothing was issued one machine cycle early. A return from interrupt updates `in_svc` at its own `mcyc_stb` edge and is observed at the start of the next machine cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  function automatic int unsigned vec_of(int unsigned idx, int unsigned base,
                                         int unsigned stride);
    return base + stride * idx;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_flags,
  input  logic               sample_stb,
  input  logic               mcyc_stb,
  output logic [NUM_SRC-1:0] poll_flags
);
  logic [NUM_SRC-1:0] samp_q, samp_d;
  logic [NUM_SRC-1:0] poll_q, poll_d;

  always_comb begin
    samp_d = samp_q;
    poll_d = poll_q;
    if (sample_stb) samp_d = irq_flags;
    if (mcyc_stb)   poll_d = samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      poll_q <= '0;
    end else begin
      samp_q <= samp_d;
      poll_q <= poll_d;
    end
  end

  assign poll_flags = poll_q;
endmodule

// File: rtl/irq_pick_first.sv
module irq_pick_first #(
  parameter int NUM_SRC = 5,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       call_fire,
  input  lvl_e       call_lvl,
  input  logic       reti_fire,
  output logic [1:0] svc
);
  logic [1:0] svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (reti_fire) begin
      if (svc_q[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (call_fire) begin
      if (call_lvl == LVL_HI) svc_d[1] = 1'b1;
      else                    svc_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 2'b00;
    else        svc_q <= svc_d;
  end

  assign svc = svc_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_flags,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_hi,
  input  logic               sample_stb,
  input  logic               mcyc_stb,
  input  logic               last_cyc,
  input  logic               reti_ins,
  input  logic               ctl_write,
  output logic               call_req,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [1:0]         in_svc
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               rst_i_n;
  logic [NUM_SRC-1:0] poll_flags;
  logic [NUM_SRC-1:0] gated;
  logic [NUM_SRC-1:0] grp_req [2];
  logic [1:0]         grp_any;
  logic [IDX_W-1:0]   grp_idx [2];
  logic [IDX_W-1:0]   win_idx;
  lvl_e               win_lvl;
  logic               lvl_ok;
  logic               gate_ok;
  logic               fire;
  logic               reti_fire;
  logic               call_q, call_d;
  logic [ADDR_W-1:0]  vec_q, vec_d;

  irq_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  irq_sampler #(.NUM_SRC(NUM_SRC)) u_samp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .irq_flags (irq_flags),
    .sample_stb(sample_stb),
    .mcyc_stb  (mcyc_stb),
    .poll_flags(poll_flags)
  );

  assign gated      = poll_flags & src_en & {NUM_SRC{glb_en}};
  assign grp_req[0] = gated & ~src_hi;
  assign grp_req[1] = gated & src_hi;

  for (genvar g = 0; g < 2; g++) begin : g_grp
    irq_pick_first #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .req(grp_req[g]),
      .any(grp_any[g]),
      .idx(grp_idx[g])
    );
  end

  always_comb begin
    win_lvl = grp_any[1] ? LVL_HI : LVL_LO;
    win_idx = grp_any[1] ? grp_idx[1] : grp_idx[0];
    lvl_ok  = (win_lvl == LVL_HI) ? !in_svc[1] : !(in_svc[1] || in_svc[0]);
    gate_ok = last_cyc && !reti_ins && !ctl_write;
    fire    = mcyc_stb && (|grp_any) && lvl_ok && gate_ok;
  end

  assign reti_fire = mcyc_stb && reti_ins && last_cyc;

  irq_svc_track u_svc (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .call_fire(fire),
    .call_lvl (win_lvl),
    .reti_fire(reti_fire),
    .svc      (in_svc)
  );

  always_comb begin
    call_d = fire;
    vec_d  = vec_q;
    if (fire) vec_d = ADDR_W'(vec_of(32'(win_idx), VEC_BASE, VEC_STRIDE));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      call_q <= call_d;
      vec_q  <= vec_d;
    end
  end

  assign call_req = call_q;
  assign vec_addr = vec_q;
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mcyc_stb,
  input logic              last_cyc,
  input logic              reti_ins,
  input logic              ctl_write,
  input logic              call_req,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [1:0]        in_svc
);
  p_call_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);

  p_vec_grid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (32'(vec_addr) >= VEC_BASE) &&
                 ((32'(vec_addr) - VEC_BASE) % VEC_STRIDE == 0));

  p_after_mcyc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(mcyc_stb));

  p_final_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(last_cyc));

  p_no_reti_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(reti_ins) && !$past(ctl_write));

  p_hi_blocks_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(in_svc[1]));

  p_svc_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (in_svc != 2'b00));

  p_reti_hi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mcyc_stb && reti_ins && last_cyc) && $past(in_svc) == 2'b11)
      |-> in_svc == 2'b01);
endmodule

bind irq_vector_ctrl irq_vec_chk #(
  .ADDR_W    (ADDR_W),
  .VEC_BASE  (VEC_BASE),
  .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mcyc_stb (mcyc_stb),
  .last_cyc (last_cyc),
  .reti_ins (reti_ins),
  .ctl_write(ctl_write),
  .call_req (call_req),
  .vec_addr (vec_addr),
  .in_svc   (in_svc)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_flags, src_en, src_hi;
  logic         glb_en, sample_stb, mcyc_stb, last_cyc, reti_ins, ctl_write;
  logic         call_req;
  logic [15:0]  vec_addr;
  logic [1:0]   in_svc;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  logic        got_call0, got_call1, early_call;
  logic [15:0] got_vec;
  logic [1:0]  got_svc;

  always #2 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_flags(irq_flags), .glb_en(glb_en),
    .src_en(src_en), .src_hi(src_hi), .sample_stb(sample_stb),
    .mcyc_stb(mcyc_stb), .last_cyc(last_cyc), .reti_ins(reti_ins),
    .ctl_write(ctl_write), .call_req(call_req), .vec_addr(vec_addr),
    .in_svc(in_svc)
  );

  typedef struct packed {
    logic [3:0]   tag;
    logic [N-1:0] f;
    logic [N-1:0] nz;
    logic         g;
    logic [N-1:0] en;
    logic [N-1:0] hi;
    logic         last;
    logic         reti;
    logic         wr;
    logic         call;
    logic [2:0]   idx;
  } row_t;

  localparam row_t TBL [12] = '{
    '{4'd8, 5'b00001, 5'b00000, 1'b1, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0}, // R8
    '{4'd3, 5'b10100, 5'b00000, 1'b1, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2}, // R3
    '{4'd3, 5'b10100, 5'b00000, 1'b1, 5'b11111, 5'b10000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4}, // R3
    '{4'd2, 5'b00001, 5'b00000, 1'b0, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R2
    '{4'd2, 5'b00011, 5'b00000, 1'b1, 5'b11110, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd1}, // R2
    '{4'd1, 5'b00000, 5'b11111, 1'b1, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R1
    '{4'd5, 5'b00001, 5'b00000, 1'b1, 5'b11111, 5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R5
    '{4'd6, 5'b00001, 5'b00000, 1'b1, 5'b11111, 5'b00000, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0}, // R6
    '{4'd6, 5'b00001, 5'b00000, 1'b1, 5'b11111, 5'b00000, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0}, // R6
    '{4'd8, 5'b01000, 5'b00000, 1'b1, 5'b11111, 5'b01000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3}, // R8
    '{4'd2, 5'b11111, 5'b00000, 1'b1, 5'b00000, 5'b00000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R2
    '{4'd1, 5'b00110, 5'b00001, 1'b1, 5'b11111, 5'b00100, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2}  // R1
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One machine cycle of six clocks: sample point on clock 4, end on clock 5.
  task automatic mcyc(input logic [N-1:0] f, input logic [N-1:0] nz,
                      input logic last, input logic reti, input logic wr);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 0) begin
        got_call0 = call_req;
        got_vec   = vec_addr;
        got_svc   = in_svc;
      end
      if (i == 1) got_call1 = call_req;
      irq_flags  = (i == 4) ? f : nz;
      sample_stb = (i == 4);
      mcyc_stb   = (i == 5);
      last_cyc   = last;
      reti_ins   = reti;
      ctl_write  = wr;
    end
  endtask

  // Capture in C1, decide in C2, observe at start of C3.
  task automatic scen(input logic [N-1:0] f, input logic [N-1:0] nz,
                      input logic last, input logic reti, input logic wr);
    mcyc(f, nz, 1'b0, 1'b0, 1'b0);
    mcyc('0, '0, last, reti, wr);
    early_call = got_call0;
    mcyc('0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic clear_svc();
    mcyc('0, '0, 1'b1, 1'b1, 1'b0);
    mcyc('0, '0, 1'b1, 1'b1, 1'b0);
    mcyc('0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    irq_flags = '0; src_en = '1; src_hi = '0; glb_en = 1'b1;
    sample_stb = 1'b0; mcyc_stb = 1'b0; last_cyc = 1'b0;
    reti_ins = 1'b0; ctl_write = 1'b0;
    repeat (3) @(negedge clk);
    chk(call_req == 1'b0, "R10 reset call", int'(call_req), 0);
    chk(in_svc == 2'b00, "R10 reset svc", int'(in_svc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table of scenarios
    for (int k = 0; k < 12; k++) begin
      row_t r = TBL[k];
      glb_en = r.g; src_en = r.en; src_hi = r.hi;
      scen(r.f, r.nz, r.last, r.reti, r.wr);
      chk(early_call == 1'b0, $sformatf("R1 row %0d no early call", k), int'(early_call), 0);
      chk(got_call0 == r.call, $sformatf("R%0d row %0d call", r.tag, k), int'(got_call0), int'(r.call));
      if (r.call) begin
        chk(got_vec == 16'(3 + 8 * int'(r.idx)), $sformatf("R8 row %0d vector", k),
            int'(got_vec), 3 + 8 * int'(r.idx));
        chk(got_call1 == 1'b0, $sformatf("R8 row %0d pulse width", k), int'(got_call1), 0);
        chk(got_svc == (r.hi[r.idx] ? 2'b10 : 2'b01), $sformatf("R9 row %0d svc", k),
            int'(got_svc), r.hi[r.idx] ? 2 : 1);
      end else begin
        chk(got_svc == 2'b00, $sformatf("R%0d row %0d svc", r.tag, k), int'(got_svc), 0);
      end
      clear_svc();
    end

    // R4: nesting rules
    glb_en = 1'b1; src_en = '1; src_hi = 5'b10000;
    scen(5'b00001, '0, 1'b1, 1'b0, 1'b0);
    chk(got_call0 && got_svc == 2'b01, "R4 low call", int'(got_svc), 1);
    scen(5'b00010, '0, 1'b1, 1'b0, 1'b0);
    chk(got_call0 == 1'b0, "R4 low over low", int'(got_call0), 0);
    scen(5'b10000, '0, 1'b1, 1'b0, 1'b0);
    chk(got_call0 == 1'b1, "R4 high preempts low", int'(got_call0), 1);
    chk(got_svc == 2'b11, "R4 both in service", int'(got_svc), 3);
    scen(5'b00010, '0, 1'b1, 1'b0, 1'b0);
    chk(got_call0 == 1'b0, "R4 low over high", int'(got_call0), 0);
    scen(5'b10000, '0, 1'b1, 1'b0, 1'b0);
    chk(got_call0 == 1'b0, "R4 high over high", int'(got_call0), 0);
    // R9: return clears highest first
    scen('0, '0, 1'b1, 1'b1, 1'b0);
    chk(got_svc == 2'b01, "R9 first return", int'(got_svc), 1);
    scen('0, '0, 1'b1, 1'b1, 1'b0);
    chk(got_svc == 2'b00, "R9 second return", int'(got_svc), 0);

    // R7: blocked request then withdrawn
    src_hi = '0;
    mcyc(5'b00100, '0, 1'b0, 1'b0, 1'b0);
    mcyc('0, '0, 1'b0, 1'b0, 1'b0);
    mcyc('0, '0, 1'b1, 1'b0, 1'b0);
    chk(got_call0 == 1'b0, "R7 blocked cycle", int'(got_call0), 0);
    mcyc('0, '0, 1'b0, 1'b0, 1'b0);
    chk(got_call0 == 1'b0, "R7 not remembered", int'(got_call0), 0);
    chk(got_svc == 2'b00, "R7 svc idle", int'(got_svc), 0);

    // R10: reset in the middle of service
    scen(5'b00001, '0, 1'b1, 1'b0, 1'b0);
    chk(got_svc == 2'b01, "R10 pre-reset svc", int'(got_svc), 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(in_svc == 2'b00, "R10 mid reset svc", int'(in_svc), 0);
    chk(call_req == 1'b0, "R10 mid reset call", int'(call_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_svc == 2'b00, "R10 after release", int'(in_svc), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule